// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction Processor Core

This block is a small processor core in which every instruction starts and finishes within one clock period. During that period the core reads the instruction word at the current program counter and decodes its operation fields. It then reads two source registers, computes an ALU result or an effective address, and reads or writes a small internal word-organised data memory. The result is written back to the register file at the next rising edge, and the program counter moves to the next sequential, branch or jump target at that same edge.

The core has two named states. `ST_HOLD` is entered whenever the synchronous reset is high. In this state the program counter is held at zero, the register file is cleared and nothing executes. A preload port may fill the instruction memory, and the data memory for test set-up, only in this state. The transition `ST_HOLD -> ST_RUN` happens on the first rising edge at which reset is low. The transition `ST_RUN -> ST_HOLD` happens on any edge at which reset is high. In `ST_RUN` one instruction is executed every cycle. A debug port shows the current program counter and the register write that will commit at the next edge.

Top module: `scc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes `ST_HOLD`, `dbg_pc` becomes 0 and every register is cleared to 0. In `ST_HOLD`, `dbg_wr_en` is 0 and `dbg_pc` does not change. The first instruction, at address 0, executes in the cycle after the first edge at which `rst` is low.
- R2: With `rst` high, `pl_we` high at a rising edge writes `pl_data` to word `pl_addr`. The word goes to the instruction memory when `pl_sel` is 0 and to the data memory when `pl_sel` is 1. When `rst` is low, `pl_we` has no effect.
- R3: Register 0 always reads as 0. A write to it is dropped and is not reported on `dbg_wr_en`.
- R4: Opcode 0x00 (bits 31:26) is the register-register group. Sources are rs (bits 25:21) and rt (bits 20:16), and the destination is rd (bits 15:11). The func field (bits 5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A set-less-than. Set-less-than compares as signed and gives 1 or 0.
- R5: Opcode 0x23 loads and opcode 0x2B stores a 32-bit word. The byte address is rs plus the sign-extended immediate in bits 15:0, and the word index is address bits above bit 1. A load writes rt. A store writes the data memory at the next edge.
- R6: Opcode 0x04 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the next PC is PC+4.
- R7: Opcode 0x02 sets the next PC to bits 31:28 of PC+4, followed by the 26-bit target in bits 25:0, followed by two zero bits.
- R8: Any other opcode, and any func value not listed in R4, writes nothing and only advances the PC by 4.
- R9: Every instruction except a taken branch or a jump advances `dbg_pc` by 4 at the next edge.
- R10: `dbg_wr_en`, `dbg_wr_idx` and `dbg_wr_data` show, during the cycle of an instruction, the register write that commits at the end of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, selects `ST_HOLD` |
| pl_we | input | 1 | Preload write strobe, honoured only in reset |
| pl_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| pl_addr | input | PL_AW | Preload word index |
| pl_data | input | 32 | Preload word |
| dbg_pc | output | 32 | Current program counter (byte address) |
| dbg_wr_en | output | 1 | A register write commits at the next edge |
| dbg_wr_idx | output | 5 | Register written |
| dbg_wr_data | output | 32 | Value written |

## Verification
The first instruction appears one cycle after reset is released: the release edge only moves the state to `ST_RUN`. After that, each instruction's register write is visible on the debug outputs during its own cycle, and its program counter effect is visible after exactly one edge. The bench releases reset at a falling edge and then samples once per falling edge. Each sample records the current program counter and any reported write. A program's whole trace is therefore compared cycle for cycle against sequences worked out from the requirements. Stores are observed through later loads. A preload write attempted while running is checked by the absence of the write it would have caused.

// File: rtl/scc_pkg.sv
package scc_pkg;
    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_JUMP  = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef enum logic {
        ST_HOLD,
        ST_RUN
    } core_state_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    use_imm;
        logic    mem_write;
        logic    load_sel;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/scc_decode.sv
module scc_decode
    import scc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] func,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{reg_write: 1'b0, dst_is_rd: 1'b0, use_imm: 1'b0,
                 mem_write: 1'b0, load_sel: 1'b0, branch: 1'b0,
                 jump: 1'b0, alu_op: ALU_ADD};
        unique case (op)
            OP_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_write = 1'b1;
                unique case (func)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_write = 1'b0;
                endcase
            end
            OP_LOAD: begin
                ctrl.reg_write = 1'b1;
                ctrl.use_imm   = 1'b1;
                ctrl.load_sel  = 1'b1;
            end
            OP_STORE: begin
                ctrl.use_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_JUMP: ctrl.jump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/scc_regfile.sv
module scc_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32
) (
    input  logic                     clk,
    input  logic                     clr,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] waddr,
    input  logic [XLEN-1:0]          wdata,
    input  logic [$clog2(NREGS)-1:0] raddr_a,
    input  logic [$clog2(NREGS)-1:0] raddr_b,
    output logic [XLEN-1:0]          rdata_a,
    output logic [XLEN-1:0]          rdata_b
);
    localparam int RW = $clog2(NREGS);

    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == RW'(0)) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == RW'(0)) ? '0 : regs[raddr_b];
endmodule

// File: rtl/scc_alu.sv
module scc_alu
    import scc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/scc_dmem.sv
module scc_dmem #(
    parameter int XLEN  = 32,
    parameter int WORDS = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [XLEN-1:0]          addr,
    input  logic [XLEN-1:0]          wdata,
    input  logic                     pl_we,
    input  logic [$clog2(WORDS)-1:0] pl_idx,
    input  logic [XLEN-1:0]          pl_data,
    output logic [XLEN-1:0]          rdata
);
    localparam int AW = $clog2(WORDS);

    logic [XLEN-1:0] mem [WORDS];
    logic [AW-1:0]   idx;
    logic            addr_unused;

    assign idx         = addr[AW+1:2];
    assign addr_unused = ^{addr[XLEN-1:AW+2], addr[1:0]};

    always_ff @(posedge clk) begin
        if (pl_we)   mem[pl_idx] <= pl_data;
        else if (we) mem[idx]    <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/scc_core.sv
module scc_core
    import scc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int PL_AW      = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pl_we,
    input  logic             pl_sel,
    input  logic [PL_AW-1:0] pl_addr,
    input  logic [31:0]      pl_data,
    output logic [31:0]      dbg_pc,
    output logic             dbg_wr_en,
    output logic [4:0]       dbg_wr_idx,
    output logic [31:0]      dbg_wr_data
);
    localparam int XLEN  = 32;
    localparam int NREGS = 32;
    localparam int IM_AW = $clog2(IMEM_WORDS);
    localparam int DM_AW = $clog2(DMEM_WORDS);

    core_state_e     state;
    logic            run;
    logic [XLEN-1:0] pc, pc4, br_tgt, j_tgt, pc_next;
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] instr;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rs_val, rt_val, imm_sx, alu_b, alu_y, ld_data;
    logic            alu_zero;
    logic [4:0]      wr_idx;
    logic [XLEN-1:0] wr_data;
    logic            wr_en;
    logic            pl_unused;

    assign pl_unused = ^pl_addr;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_HOLD;
        else     state <= ST_RUN;
    end

    assign run = (state == ST_RUN);

    // program counter
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            unique case (state)
                ST_HOLD: pc <= pc;
                ST_RUN:  pc <= pc_next;
                default: pc <= '0;
            endcase
        end
    end

    // instruction memory, writable only under reset
    always_ff @(posedge clk) begin
        if (rst && pl_we && !pl_sel) imem[pl_addr[IM_AW-1:0]] <= pl_data;
    end

    assign instr = imem[pc[IM_AW+1:2]];

    scc_decode u_dec (
        .op   (instr[31:26]),
        .func (instr[5:0]),
        .ctrl (ctrl)
    );

    scc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
        .clk     (clk),
        .clr     (rst),
        .we      (wr_en),
        .waddr   (wr_idx),
        .wdata   (wr_data),
        .raddr_a (instr[25:21]),
        .raddr_b (instr[20:16]),
        .rdata_a (rs_val),
        .rdata_b (rt_val)
    );

    assign imm_sx = {{16{instr[15]}}, instr[15:0]};
    assign alu_b  = ctrl.use_imm ? imm_sx : rt_val;

    scc_alu #(.XLEN(XLEN)) u_alu (
        .op   (ctrl.alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    scc_dmem #(.XLEN(XLEN), .WORDS(DMEM_WORDS)) u_dm (
        .clk     (clk),
        .we      (run && ctrl.mem_write),
        .addr    (alu_y),
        .wdata   (rt_val),
        .pl_we   (rst && pl_we && pl_sel),
        .pl_idx  (pl_addr[DM_AW-1:0]),
        .pl_data (pl_data),
        .rdata   (ld_data)
    );

    // next-PC selection
    assign pc4    = pc + XLEN'(4);
    assign br_tgt = pc4 + {imm_sx[XLEN-3:0], 2'b00};
    assign j_tgt  = {pc4[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctrl.jump)                   pc_next = j_tgt;
        else if (ctrl.branch && alu_zero) pc_next = br_tgt;
        else                             pc_next = pc4;
    end

    // write-back
    assign wr_idx  = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
    assign wr_data = ctrl.load_sel ? ld_data : alu_y;
    assign wr_en   = run && ctrl.reg_write && (wr_idx != 5'd0);

    // outputs
    always_comb begin
        dbg_pc      = pc;
        dbg_wr_en   = wr_en;
        dbg_wr_idx  = wr_idx;
        dbg_wr_data = wr_data;
    end
endmodule

// File: rtl/scc_core_chk.sv
module scc_core_chk
    import scc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        run,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [31:0] dbg_pc,
    input logic        dbg_wr_en,
    input logic [4:0]  dbg_wr_idx
);
    a_r1_reset_pc: assert property (@(posedge clk)
        rst |=> dbg_pc == 32'd0);

    a_r1_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        !run |-> !dbg_wr_en);

    a_r3_no_zero_write: assert property (@(posedge clk) disable iff (rst)
        dbg_wr_en |-> dbg_wr_idx != 5'd0);

    // R9, R8
    a_r9_sequential: assert property (@(posedge clk) disable iff (rst)
        (run && instr[31:26] != OP_BEQ && instr[31:26] != OP_JUMP)
        |=> dbg_pc == $past(dbg_pc) + 32'd4);

    a_r6_not_taken: assert property (@(posedge clk) disable iff (rst)
        (run && instr[31:26] == OP_BEQ && rs_val != rt_val)
        |=> dbg_pc == $past(dbg_pc) + 32'd4);

    a_r6_taken: assert property (@(posedge clk) disable iff (rst)
        (run && instr[31:26] == OP_BEQ && rs_val == rt_val)
        |=> dbg_pc == $past(dbg_pc) + 32'd4
                      + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

    a_r7_jump: assert property (@(posedge clk) disable iff (rst)
        (run && instr[31:26] == OP_JUMP)
        |=> dbg_pc[27:0] == {$past(instr[25:0]), 2'b00});

    a_r1_hold_pc: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(dbg_pc));
endmodule

bind scc_core scc_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .instr      (instr),
    .rs_val     (rs_val),
    .rt_val     (rt_val),
    .dbg_pc     (dbg_pc),
    .dbg_wr_en  (dbg_wr_en),
    .dbg_wr_idx (dbg_wr_idx)
);

// File: tb/scc_core_test.sv
module scc_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pl_we = 1'b0;
    logic        pl_sel = 1'b0;
    logic [5:0]  pl_addr = '0;
    logic [31:0] pl_data = '0;
    logic [31:0] dbg_pc;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_idx;
    logic [31:0] dbg_wr_data;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] tr_pc  [MAXT];
    logic [4:0]  wl_idx [MAXT];
    logic [31:0] wl_dat [MAXT];
    int          wl_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    scc_core uut (
        .clk(clk), .rst(rst), .pl_we(pl_we), .pl_sel(pl_sel),
        .pl_addr(pl_addr), .pl_data(pl_data), .dbg_pc(dbg_pc),
        .dbg_wr_en(dbg_wr_en), .dbg_wr_idx(dbg_wr_idx), .dbg_wr_data(dbg_wr_data)
    );

    function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic preload(input bit sel, input int idx, input logic [31:0] data);
        pl_we = 1'b1; pl_sel = sel; pl_addr = 6'(idx); pl_data = data;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic enter_reset();
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 64; i++) preload(1'b0, i, 32'h0);
    endtask

    task automatic run_trace(input int n, input int inject_at);
        wl_n = 0;
        rst = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (i == inject_at) begin
                pl_we = 1'b1; pl_sel = 1'b0; pl_addr = 6'd11;
                pl_data = itype(6'h23, 0, 5, 16'h0000);
            end
            @(negedge clk);
            pl_we = 1'b0;
            tr_pc[i] = dbg_pc;
            if (dbg_wr_en && wl_n < MAXT) begin
                wl_idx[wl_n] = dbg_wr_idx;
                wl_dat[wl_n] = dbg_wr_data;
                wl_n++;
            end
        end
    endtask

    task automatic check_write(input string req, input int k, input int idx, input logic [31:0] val);
        check(k < wl_n, req, "write present", 32'(wl_n), 32'(k + 1));
        if (k < wl_n) begin
            check(wl_idx[k] == 5'(idx), req, "write index", 32'(wl_idx[k]), 32'(idx));
            check(wl_dat[k] == val, req, "write data", wl_dat[k], val);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        enter_reset();
        check(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
        check(dbg_wr_en == 1'b0, "R1", "no write in reset", 32'(dbg_wr_en), 32'd0);
    endtask

    // R4, R3, R9, R10: ALU program
    task automatic t_alu();
        enter_reset();
        preload(1'b1, 0, 32'd5);
        preload(1'b1, 1, 32'hFFFF_FFFD);
        preload(1'b0, 0, itype(6'h23, 0, 1, 16'd0));
        preload(1'b0, 1, itype(6'h23, 0, 2, 16'd4));
        preload(1'b0, 2, rtype(1, 2, 3, 6'h20));
        preload(1'b0, 3, rtype(1, 2, 4, 6'h22));
        preload(1'b0, 4, rtype(1, 2, 5, 6'h24));
        preload(1'b0, 5, rtype(1, 2, 6, 6'h25));
        preload(1'b0, 6, rtype(2, 1, 7, 6'h2A));
        preload(1'b0, 7, rtype(1, 2, 8, 6'h2A));
        preload(1'b0, 8, rtype(1, 1, 0, 6'h20));
        preload(1'b0, 9, rtype(0, 1, 9, 6'h20));
        run_trace(10, -1);
        for (int i = 0; i < 10; i++)
            check(tr_pc[i] == 32'(4 * i), "R9", "sequential pc", tr_pc[i], 32'(4 * i));
        check(wl_n == 9, "R3", "write count (r0 dropped)", 32'(wl_n), 32'd9);
        check_write("R10", 0, 1, 32'd5);
        check_write("R10", 1, 2, 32'hFFFF_FFFD);
        check_write("R4", 2, 3, 32'd2);
        check_write("R4", 3, 4, 32'd8);
        check_write("R4", 4, 5, 32'd5);
        check_write("R4", 5, 6, 32'hFFFF_FFFD);
        check_write("R4", 6, 7, 32'd1);
        check_write("R4", 7, 8, 32'd0);
        check_write("R3", 8, 9, 32'd5);
    endtask

    // R5, R1 (register clear), R2 (data preload)
    task automatic t_mem();
        enter_reset();
        preload(1'b1, 0, 32'd5);
        preload(1'b1, 2, 32'd8);
        preload(1'b0, 0, rtype(1, 2, 14, 6'h20));
        preload(1'b0, 1, itype(6'h23, 0, 1, 16'd0));
        preload(1'b0, 2, itype(6'h23, 0, 12, 16'd8));
        preload(1'b0, 3, itype(6'h2B, 0, 1, 16'd12));
        preload(1'b0, 4, itype(6'h23, 0, 10, 16'd12));
        preload(1'b0, 5, itype(6'h2B, 12, 12, 16'hFFFC));
        preload(1'b0, 6, itype(6'h23, 0, 13, 16'd4));
        run_trace(7, -1);
        check(wl_n == 5, "R5", "write count", 32'(wl_n), 32'd5);
        check_write("R1", 0, 14, 32'd0);
        check_write("R2", 1, 1, 32'd5);
        check_write("R5", 2, 12, 32'd8);
        check_write("R5", 3, 10, 32'd5);
        check_write("R5", 4, 13, 32'd8);
    endtask

    // R6, R7, R2 (preload ignored while running)
    task automatic t_flow();
        logic [31:0] exp_pc [10];
        exp_pc = '{0, 4, 8, 20, 24, 40, 44, 44, 44, 44};
        enter_reset();
        preload(1'b1, 0, 32'd5);
        preload(1'b1, 1, 32'h1234_5678);
        preload(1'b0, 0, itype(6'h23, 0, 1, 16'd0));
        preload(1'b0, 1, itype(6'h23, 0, 2, 16'd0));
        preload(1'b0, 2, itype(6'h04, 1, 2, 16'd2));
        preload(1'b0, 3, itype(6'h23, 0, 3, 16'd0));
        preload(1'b0, 4, itype(6'h23, 0, 3, 16'd0));
        preload(1'b0, 5, itype(6'h04, 1, 0, 16'd1));
        preload(1'b0, 6, {6'h02, 26'd10});
        preload(1'b0, 10, itype(6'h23, 0, 4, 16'd4));
        preload(1'b0, 11, itype(6'h04, 0, 0, 16'hFFFF));
        run_trace(10, 6);
        check(tr_pc[3] == exp_pc[3], "R6", "taken branch target", tr_pc[3], exp_pc[3]);
        check(tr_pc[4] == exp_pc[4], "R6", "not-taken branch", tr_pc[4], exp_pc[4]);
        check(tr_pc[5] == exp_pc[5], "R7", "jump target", tr_pc[5], exp_pc[5]);
        for (int i = 6; i < 10; i++)
            check(tr_pc[i] == exp_pc[i], "R6", "backward self branch", tr_pc[i], exp_pc[i]);
        check(wl_n == 3, "R2", "no write from run-time preload", 32'(wl_n), 32'd3);
        check_write("R6", 0, 1, 32'd5);
        check_write("R6", 1, 2, 32'd5);
        check_write("R7", 2, 4, 32'h1234_5678);
    endtask

    // R8: unsupported encodings
    task automatic t_unsupported();
        enter_reset();
        preload(1'b1, 0, 32'd5);
        preload(1'b0, 0, itype(6'h08, 0, 5, 16'd7));
        preload(1'b0, 1, rtype(0, 1, 6, 6'h03));
        preload(1'b0, 2, itype(6'h23, 0, 7, 16'd0));
        run_trace(3, -1);
        check(tr_pc[1] == 32'd4, "R8", "pc after unknown op", tr_pc[1], 32'd4);
        check(tr_pc[2] == 32'd8, "R8", "pc after unknown func", tr_pc[2], 32'd8);
        check(wl_n == 1, "R8", "only the load writes", 32'(wl_n), 32'd1);
        check_write("R8", 0, 7, 32'd5);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_alu();
        t_mem();
        t_flow();
        t_unsupported();
        t_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule